// File: doc/BRIEF.md
# Global-History Two-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each static branch owns an entry index, and for every entry the block keeps one two-bit saturating state per global-history pattern. A short global history register holds the outcomes of the most recent resolved branches, across all branches. Its value chooses which set of states is consulted on a prediction and which set is changed on an update. The history length is a parameter of 0, 1 or 2 bits. With 0 bits the block reduces to a plain per-entry two-bit predictor.

A front end presents an entry index on the predict port and gets a taken/not-taken answer in the same cycle. When a branch resolves, the back end presents its entry index and actual outcome on the update port. On that clock edge the selected state moves one step and the outcome is shifted into the history. Different branches are given different indexes by the user, so entries never alias. There is no target prediction, no tag check and no history repair.

The state encoding is unusual: states whose upper bit is 1 predict not-taken, and states whose upper bit is 0 predict taken. Taken outcomes walk 10, 11, 00, 01 and stop at 01. Not-taken outcomes walk the same chain backwards and stop at 10.

Top module: `gh_branch_predictor`

## Requirements
- R1: After reset every two-bit state holds 10 and the history register holds all ones, so every entry predicts not-taken.
- R2: `pred_taken` is 1 exactly when the upper bit of the state selected by `pred_idx` and the current history is 0, and it follows `pred_idx` in the same cycle.
- R3: A taken update moves the selected state 10 to 11, 11 to 00, 00 to 01, and leaves 01 at 01.
- R4: A not-taken update moves the selected state 01 to 00, 00 to 11, 11 to 10, and leaves 10 at 10.
- R5: On an update the outcome (taken = 1) enters the most significant history bit and the previous upper bit moves down one place; with a one-bit history the bit becomes the latest outcome.
- R6: The history value, read as a binary number, selects state set 0 to 2^HIST_BITS-1; a prediction uses the current history, and an update changes only the state in the set chosen by the history before that update.
- R7: An update to one entry leaves the states of every other entry unchanged.
- R8: With HIST_BITS = 0 a single state set is used and the outcome history has no effect.
- R9: While `upd_valid` is 0 no state and no history bit changes, whatever `upd_idx` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_idx | input | IDX_W | Entry index of the branch being predicted |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | An outcome is presented this cycle |
| upd_idx | input | IDX_W | Entry index of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives one stimulus stream into three copies of the block, with zero, one and two history bits, and compares each against its own reference. The corner cases are the two saturation points and the 11-to-00 wrap in the middle of the chain. A design with an off-by-one chain would flip a prediction one outcome too early or too late. A design that saturated at the wrong end would never return from 01 or from 10. Set selection is probed with sequences that change history between updates of one entry. A design that wrote with the post-update history, or shifted history the wrong way, would train a counter in the wrong set and mispredict later. Idle cycles with a busy index and outcome, and repeated updates to one entry, catch writes that leak without `upd_valid` or spill into a neighbouring entry.

// File: rtl/gh_bp_pkg.sv
package gh_bp_pkg;

   typedef logic [1:0] bp_ctr_t;

   localparam bp_ctr_t CTR_RESET = 2'b10;

   // one step along the chain 10 - 11 - 00 - 01
   function automatic bp_ctr_t ctr_step(input bp_ctr_t cur, input logic taken);
      bp_ctr_t nxt;
      if (taken) begin
         case (cur)
            2'b10:   nxt = 2'b11;
            2'b11:   nxt = 2'b00;
            2'b00:   nxt = 2'b01;
            default: nxt = 2'b01;
         endcase
      end else begin
         case (cur)
            2'b01:   nxt = 2'b00;
            2'b00:   nxt = 2'b11;
            2'b11:   nxt = 2'b10;
            default: nxt = 2'b10;
         endcase
      end
      return nxt;
   endfunction

   // upper bit clear means taken
   function automatic logic ctr_says_taken(input bp_ctr_t cur);
      return ~cur[1];
   endfunction

endpackage

// File: rtl/bp_ctr_cell.sv
module bp_ctr_cell
   import gh_bp_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  logic    wr_taken,
   output bp_ctr_t state
);

   always_ff @(posedge clk) begin
      if (!rst_n)     state <= CTR_RESET;
      else if (wr_en) state <= ctr_step(state, wr_taken);
   end

   p_top_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && state == 2'b01) |=> state == 2'b01);

   p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_taken && state == 2'b11) |=> state == 2'b00);

   p_bottom_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_taken && state == 2'b10) |=> state == 2'b10);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(state));

endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
   import gh_bp_pkg::*;
#(
   parameter int NUM_SETS    = 4,
   parameter int NUM_ENTRIES = 8,
   parameter int SET_W       = 2,
   parameter int IDX_W       = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_taken,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   localparam int TOTAL = NUM_SETS * NUM_ENTRIES;

   bp_ctr_t    cells [TOTAL];
   logic [TOTAL-1:0] cell_we;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
         assign cell_we[s*NUM_ENTRIES+e] = wr_en
                                           && (wr_set == SET_W'(s))
                                           && (wr_idx == IDX_W'(e));
         bp_ctr_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cell_we[s*NUM_ENTRIES+e]),
            .wr_taken (wr_taken),
            .state    (cells[s*NUM_ENTRIES+e])
         );
      end
   end

   always_comb begin
      rd_taken = 1'b0;
      for (int s = 0; s < NUM_SETS; s++) begin
         for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (rd_set == SET_W'(s) && rd_idx == IDX_W'(e))
               rd_taken = ctr_says_taken(cells[s*NUM_ENTRIES+e]);
         end
      end
   end

   p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cell_we));

   p_no_write_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> cell_we == '0);

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
   parameter int HIST_BITS = 2,
   parameter int HW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          upd_valid,
   input  logic          upd_taken,
   output logic [HW-1:0] hist
);

   if (HIST_BITS == 0) begin : g_none
      assign hist = '0;
   end else if (HIST_BITS == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (!rst_n)         hist <= '1;
         else if (upd_valid) hist <= upd_taken;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n)         hist <= '1;
         else if (upd_valid) hist <= {upd_taken, hist[HW-1:1]};
      end

      p_shift_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
         upd_valid |=> hist[HW-2] == $past(hist[HW-1]));
   end

   if (HIST_BITS > 0) begin : g_chk
      p_newest_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
         upd_valid |=> hist[HW-1] == $past(upd_taken));

      p_hist_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !upd_valid |=> $stable(hist));
   end

endmodule

// File: rtl/gh_branch_predictor.sv
module gh_branch_predictor
   import gh_bp_pkg::*;
#(
   parameter int NUM_ENTRIES = 8,
   parameter int HIST_BITS   = 2,
   localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] pred_idx,
   output logic             pred_taken,
   input  logic             upd_valid,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_taken
);

   localparam int HW       = (HIST_BITS == 0) ? 1 : HIST_BITS;
   localparam int NUM_SETS = 1 << HIST_BITS;

   initial begin
      assert (HIST_BITS >= 0 && HIST_BITS <= 2)
         else $error("HIST_BITS must be 0, 1 or 2");
      assert (NUM_ENTRIES >= 2)
         else $error("NUM_ENTRIES must be at least 2");
   end

   logic [HW-1:0] hist;

   bp_ghist #(
      .HIST_BITS (HIST_BITS),
      .HW        (HW)
   ) u_hist (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (upd_valid),
      .upd_taken (upd_taken),
      .hist      (hist)
   );

   // the write uses the history as it stands before this edge
   bp_ctr_bank #(
      .NUM_SETS    (NUM_SETS),
      .NUM_ENTRIES (NUM_ENTRIES),
      .SET_W       (HW),
      .IDX_W       (IDX_W)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (hist),
      .rd_idx   (pred_idx),
      .rd_taken (pred_taken),
      .wr_en    (upd_valid),
      .wr_set   (hist),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken)
   );

   if (HIST_BITS == 0) begin : g_flat_chk
      p_single_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
         hist == '0);
   end

endmodule

// File: tb/test_gh_branch_predictor.sv
`timescale 1ns/1ps
module test_gh_branch_predictor;

   localparam int N  = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] pred_idx = '0;
   logic          upd_valid = 1'b0;
   logic [IW-1:0] upd_idx = '0;
   logic          upd_taken = 1'b0;
   logic          pt [3];

   int n_checks = 0;
   int n_fail   = 0;

   always #2.5 clk = ~clk;

   gh_branch_predictor #(.NUM_ENTRIES(N), .HIST_BITS(2)) i_gh_branch_predictor (
      .clk(clk), .rst_n(rst_n), .pred_idx(pred_idx), .pred_taken(pt[2]),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken));

   gh_branch_predictor #(.NUM_ENTRIES(N), .HIST_BITS(1)) i_gh_branch_predictor_h1 (
      .clk(clk), .rst_n(rst_n), .pred_idx(pred_idx), .pred_taken(pt[1]),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken));

   gh_branch_predictor #(.NUM_ENTRIES(N), .HIST_BITS(0)) i_gh_branch_predictor_h0 (
      .clk(clk), .rst_n(rst_n), .pred_idx(pred_idx), .pred_taken(pt[0]),
      .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_taken(upd_taken));

   // reference: per configuration k (history bits), history and states
   int         m_hist [3];
   logic [1:0] m_ctr  [3][4][N];

   function automatic logic [1:0] ref_step(logic [1:0] c, logic t);
      if (t) return (c == 2'b10) ? 2'b11 : (c == 2'b11) ? 2'b00 : 2'b01;
      else   return (c == 2'b01) ? 2'b00 : (c == 2'b00) ? 2'b11 : 2'b10;
   endfunction

   task automatic model_reset();
      for (int k = 0; k < 3; k++) begin
         m_hist[k] = (1 << k) - 1;
         for (int s = 0; s < 4; s++)
            for (int e = 0; e < N; e++) m_ctr[k][s][e] = 2'b10;
      end
   endtask

   task automatic model_update(int idx, logic t);
      for (int k = 0; k < 3; k++) begin
         m_ctr[k][m_hist[k]][idx] = ref_step(m_ctr[k][m_hist[k]][idx], t);
         if (k == 1)      m_hist[k] = int'(t);
         else if (k == 2) m_hist[k] = (int'(t) << 1) | (m_hist[k] >> 1);
      end
   endtask

   task automatic chk(logic act, logic exp, string tag);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", tag, act, exp);
      end
   endtask

   task automatic peek(int idx);
      pred_idx = IW'(idx);
      #0.5;
   endtask

   // every configuration, every entry, against the reference
   task automatic check_all(string tag);
      for (int e = 0; e < N; e++) begin
         peek(e);
         for (int k = 0; k < 3; k++)
            chk(pt[k], ~m_ctr[k][m_hist[k]][e][1], $sformatf("%s cfg%0d idx%0d", tag, k, e));
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      upd_valid = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic upd(int idx, logic t);
      @(negedge clk);
      upd_valid = 1'b1;
      upd_idx   = IW'(idx);
      upd_taken = t;
      @(negedge clk);
      upd_valid = 1'b0;
      model_update(idx, t);
   endtask

   task automatic t_reset();
      do_reset();
      for (int e = 0; e < N; e++) begin
         peek(e);
         for (int k = 0; k < 3; k++) chk(pt[k], 1'b0, "R1 reset predicts not-taken");
      end
   endtask

   // chain walk on the history-free copy with fixed expectations
   task automatic t_walk();
      logic exp_t [9] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
      logic out_t [9] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      do_reset();
      for (int i = 0; i < 9; i++) begin
         upd(0, out_t[i]);
         peek(0);
         chk(pt[0], exp_t[i], $sformatf("%s step %0d", out_t[i] ? "R3" : "R4", i));
      end
      // 10 -> 11 after the last taken: not-taken
      check_all("R8 walk");
   endtask

   // two-bit history: sets chosen by pre-update history
   task automatic t_sets();
      do_reset();
      upd(1, 1'b0);               // set3 e1 stays 10, hist 01
      upd(1, 1'b1);               // set1 e1 -> 11, hist 10
      upd(1, 1'b1);               // set2 e1 -> 11, hist 11
      upd(1, 1'b1);               // set3 e1 -> 11, hist 11
      upd(1, 1'b1);               // set3 e1 -> 00, hist 11
      peek(1); chk(pt[2], 1'b1, "R6 set3 trained taken");
      upd(0, 1'b0);               // hist 01
      peek(1); chk(pt[2], 1'b0, "R6 set1 separate");
      upd(0, 1'b1);               // hist 10
      peek(1); chk(pt[2], 1'b0, "R5 history 10 selects set2");
      check_all("R5 R6 sets");
   endtask

   task automatic t_one_bit();
      do_reset();
      upd(3, 1'b1);               // set1 e3 -> 11
      upd(3, 1'b1);               // set1 e3 -> 00
      peek(3); chk(pt[1], 1'b1, "R5 one-bit set1");
      upd(3, 1'b0);               // set1 e3 -> 11, hist 0
      peek(3); chk(pt[1], 1'b0, "R5 one-bit set0 untouched");
      check_all("R5 one-bit");
   endtask

   task automatic t_isolation();
      do_reset();
      for (int i = 0; i < 6; i++) upd(5, 1'b1);
      for (int e = 0; e < N; e++) begin
         if (e == 5) continue;
         peek(e);
         chk(pt[0], 1'b0, "R7 neighbour untouched");
      end
      check_all("R7 isolation");
   endtask

   task automatic t_idle();
      do_reset();
      upd(2, 1'b1); upd(2, 1'b1); upd(4, 1'b0);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         upd_idx   = IW'(i);
         upd_taken = i[0];
      end
      check_all("R9 idle");
   endtask

   task automatic t_pattern();
      int lfsr = 16'hACE1;
      do_reset();
      for (int it = 0; it < 16; it++) begin
         upd(0, it[0]);            // alternating branch
         upd(1, it != 15);         // loop-closing branch
      end
      check_all("R2 loop pattern");
      for (int it = 0; it < 120; it++) begin
         lfsr = ((lfsr >> 1) | ((((lfsr >> 0) ^ (lfsr >> 2) ^ (lfsr >> 3) ^ (lfsr >> 5)) & 1) << 15)) & 16'hFFFF;
         upd(lfsr & 7, lfsr[8]);
         if (it % 20 == 19) check_all("R2 R6 mixed");
      end
   endtask

   initial begin
      #1000000;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      model_reset();
      t_reset();
      t_walk();
      t_sets();
      t_one_bit();
      t_isolation();
      t_idle();
      t_pattern();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule